// File: doc/BRIEF.md
# BT.656 Capture Window Extractor

The block takes an 8-bit BT.656 byte stream, with one byte on every rising edge of the pixel clock. It finds the four-byte timing reference codes in that stream and decodes the field, vertical-blanking and horizontal flags from each one. It discards any code whose protection nibble is inconsistent. The decoded codes drive a horizontal sample counter and a per-field active-line counter. Those counters gate which samples reach capture, using a rectangle that is programmed separately for each field.

Samples inside the rectangle are split by their position in the multiplexed chroma/luma sequence into three lanes: luma, blue-difference and red-difference. Each lane packs its bytes into 64-bit words, with the earliest byte in the least significant position. Any partial word is pushed out when an active line ends. A pulse marks the end of each selected field. A second pulse marks a completed frame when both fields are selected. A third pulse reports each rejected code.

Top module: `bt656_window_capture`

## Requirements
- R1: A code is the bytes FFh, 00h, 00h followed by a flag byte in which bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H. An accepted code with V=0 and H=0 opens the active line, and the byte that follows it is horizontal sample 0.
- R2: The flag byte's bits 3..0 must equal {V^H, F^H, F^V, F^V^H}, and bit 7 must be 1. When this fails, `sync_err` is high for exactly one cycle, one clock after the flag byte, and the code changes no state. An accepted code leaves `sync_err` low.
- R3: An FFh byte during an active line ends that line. Bytes received outside an active line are never captured.
- R4: Within an active line, sample index modulo 4 selects the lane: 0 goes to Cb, 1 to Y, 2 to Cr and 3 to Y. The pixel number of a sample is its index divided by 2.
- R5: A sample is captured only when its pixel number lies between the field's first and last column, both inclusive.
- R6: The line counter is 1 on the first active line after a code with V=1 or after a field change. It rises by one with each further active line. A line is captured only when the counter lies between the field's first and last line, both inclusive.
- R7: The effective field is F XOR `fld_inv`. Effective field 0 uses the f1 window and `cap_f1`. Effective field 1 uses the f2 window and `cap_f2`. A field that is not selected captures nothing.
- R8: Each lane packs 8 captured bytes into one word, with the first byte in bits 7:0. The lane's valid output pulses for one cycle, in the clock after the eighth byte.
- R9: When an active line ends, each lane holding 1 to 7 bytes outputs them as a word whose unused upper bytes are zero. This happens one clock after the FFh byte.
- R10: The first accepted code with V=1 after active lines of a selected field pulses `field_done` one clock after its flag byte, and `field_done_id` gives that field's effective number.
- R11: With both fields selected, the `field_done` pulse for effective field 1 also pulses `frame_done`, provided effective field 0 completed since the last frame pulse.
- R12: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | BT.656 byte stream |
| fld_inv | input | 1 | Inverts the decoded field bit |
| cap_f1 | input | 1 | Capture enable for effective field 0 |
| cap_f2 | input | 1 | Capture enable for effective field 1 |
| f1_x_first | input | 11 | First captured pixel, field 0 |
| f1_x_last | input | 11 | Last captured pixel, field 0 |
| f1_line_first | input | 11 | First captured line, field 0 |
| f1_line_last | input | 11 | Last captured line, field 0 |
| f2_x_first | input | 11 | First captured pixel, field 1 |
| f2_x_last | input | 11 | Last captured pixel, field 1 |
| f2_line_first | input | 11 | First captured line, field 1 |
| f2_line_last | input | 11 | Last captured line, field 1 |
| y_word | output | 64 | Packed luma word |
| y_vld | output | 1 | Luma word valid pulse |
| cb_word | output | 64 | Packed blue-difference word |
| cb_vld | output | 1 | Blue-difference word valid pulse |
| cr_word | output | 64 | Packed red-difference word |
| cr_vld | output | 1 | Red-difference word valid pulse |
| field_done | output | 1 | Selected field finished |
| field_done_id | output | 1 | Effective field number of the finished field |
| frame_done | output | 1 | Both fields of a frame finished |
| sync_err | output | 1 | Rejected code pulse |

## Verification
On every cycle, the assertions check the following. A rejected code leaves the line and field state untouched. A start code zeroes the sample counter, and after blanking it sets the line counter to 1. No lane is written outside an active line, and at most one lane is written per byte. A full or flushed word empties its lane, with zero padding for a one-byte flush. A frame pulse comes only together with the completion of field 1.

Only the directed scenarios can show the rest. These cover the actual packed byte values and their order, the placement of the window edges for each field, the effect of field inversion and of field selection, and the fact that a corrupted start code lets no following byte through.

// File: rtl/bt_cap_pkg.sv
package bt_cap_pkg;

    localparam int HCW    = 12;            // sample counter width (bytes of a line)
    localparam int XW     = HCW - 1;       // pixel coordinate width
    localparam int VW     = 11;            // line counter width
    localparam int WBYTES = 8;             // bytes per packed word
    localparam int WW     = WBYTES * 8;    // packed word width
    localparam int LANES  = 3;

    localparam int LANE_Y  = 0;
    localparam int LANE_CB = 1;
    localparam int LANE_CR = 2;

    localparam logic [7:0] SYNC_HI = 8'hFF;
    localparam logic [7:0] SYNC_LO = 8'h00;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    typedef struct packed {
        logic          en;
        logic [XW-1:0] xs;
        logic [XW-1:0] xe;
        logic [VW-1:0] ys;
        logic [VW-1:0] ye;
    } win_cfg_t;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } sample_phase_e;

    function automatic logic [3:0] trs_prot(input trs_flags_t fl);
        return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction

endpackage

// File: rtl/bt_trs_decode.sv
module bt_trs_decode
    import bt_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    output logic       code_hit,
    output logic       code_ok,
    output trs_flags_t flags,
    output logic       sync_err
);

    logic [7:0] hist1, hist2, hist3;

    always_comb begin
        code_hit = (hist3 == SYNC_HI) && (hist2 == SYNC_LO) && (hist1 == SYNC_LO);
        flags.f  = din[6];
        flags.v  = din[5];
        flags.h  = din[4];
        code_ok  = din[7] && (din[3:0] == trs_prot(flags));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist1    <= '0;
            hist2    <= '0;
            hist3    <= '0;
            sync_err <= 1'b0;
        end else begin
            hist1    <= din;
            hist2    <= hist1;
            hist3    <= hist2;
            sync_err <= code_hit && !code_ok;
        end
    end

endmodule

// File: rtl/bt_line_tracker.sv
module bt_line_tracker
    import bt_cap_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     din,
    input  logic           code_hit,
    input  logic           code_ok,
    input  trs_flags_t     flags,
    input  logic           fld_inv,
    input  logic [1:0]     cap_sel,
    output logic           active,
    output logic [HCW-1:0] hcount,
    output logic [VW-1:0]  vcount,
    output logic           field,
    output logic           line_end,
    output logic           field_done,
    output logic           field_done_id,
    output logic           frame_done
);

    localparam logic [HCW-1:0] HMAX = '1;
    localparam logic [VW-1:0]  VMAX = '1;

    logic good;
    logic new_field;
    logic blank_seen;
    logic live;
    logic f1_got;

    always_comb begin
        good      = code_hit && code_ok;
        new_field = flags.f ^ fld_inv;
        line_end  = active && (din == SYNC_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active        <= 1'b0;
            hcount        <= '0;
            vcount        <= '0;
            field         <= 1'b0;
            blank_seen    <= 1'b1;
            live          <= 1'b0;
            f1_got        <= 1'b0;
            field_done    <= 1'b0;
            field_done_id <= 1'b0;
            frame_done    <= 1'b0;
        end else begin
            field_done <= 1'b0;
            frame_done <= 1'b0;
            if (good) begin
                field <= new_field;
                if (flags.v) begin
                    active     <= 1'b0;
                    blank_seen <= 1'b1;
                    if (live) begin
                        live <= 1'b0;
                        if (cap_sel[field]) begin
                            field_done    <= 1'b1;
                            field_done_id <= field;
                            if (!field) begin
                                f1_got <= cap_sel[1];
                            end else begin
                                frame_done <= f1_got;
                                f1_got     <= 1'b0;
                            end
                        end
                    end
                end else if (!flags.h) begin
                    active     <= 1'b1;
                    hcount     <= '0;
                    live       <= 1'b1;
                    blank_seen <= 1'b0;
                    if (blank_seen || (new_field != field)) begin
                        vcount <= VW'(1);
                    end else if (vcount != VMAX) begin
                        vcount <= vcount + 1'b1;
                    end
                end else begin
                    active <= 1'b0;
                end
            end else if (line_end) begin
                active <= 1'b0;
            end else if (active && (hcount != HMAX)) begin
                hcount <= hcount + 1'b1;
            end
        end
    end

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (code_hit && !code_ok) |=> ($stable(active) && $stable(field) && $stable(vcount))); // R2

    AST_SAV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (good && !flags.v && !flags.h) |=> (active && hcount == '0)); // R1

    AST_VSTART_ONE: assert property (@(posedge clk) disable iff (rst)
        (good && !flags.v && !flags.h && blank_seen) |=> (vcount == VW'(1))); // R6

    AST_FRAME_WITH_FIELD2: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (field_done && field_done_id)); // R11

endmodule

// File: rtl/bt_win_gate.sv
module bt_win_gate
    import bt_cap_pkg::*;
(
    input  logic             active,
    input  logic             line_end,
    input  logic [HCW-1:0]   hcount,
    input  logic [VW-1:0]    vcount,
    input  logic             field,
    input  win_cfg_t         cfg [2],
    output logic [LANES-1:0] lane_we
);

    win_cfg_t      sel;
    logic [XW-1:0] pix;
    sample_phase_e phase;
    logic          in_win;

    always_comb begin
        sel    = cfg[field];
        pix    = hcount[HCW-1:1];
        phase  = sample_phase_e'(hcount[1:0]);
        in_win = active && !line_end && sel.en &&
                 (pix >= sel.xs) && (pix <= sel.xe) &&
                 (vcount >= sel.ys) && (vcount <= sel.ye);
        lane_we = '0;
        if (in_win) begin
            unique case (phase)
                PH_CB:        lane_we[LANE_CB] = 1'b1;
                PH_CR:        lane_we[LANE_CR] = 1'b1;
                PH_Y0, PH_Y1: lane_we[LANE_Y]  = 1'b1;
                default:      lane_we          = '0;
            endcase
        end
    end

endmodule

// File: rtl/bt_word_pack.sv
module bt_word_pack #(
    parameter int NB = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            flush,
    input  logic [7:0]      bin,
    output logic [NB*8-1:0] word,
    output logic            vld
);

    localparam int WWL  = NB * 8;
    localparam int CNTW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(NB - 1);

    logic [WWL-1:0]  acc;
    logic [CNTW-1:0] cnt;
    logic [WWL-1:0]  placed;

    always_comb begin
        placed = {{(WWL-8){1'b0}}, bin} << {cnt, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            cnt  <= '0;
            word <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (we) begin
                if (cnt == LAST) begin
                    word <= acc | placed;
                    vld  <= 1'b1;
                    acc  <= '0;
                    cnt  <= '0;
                end else begin
                    acc <= acc | placed;
                    cnt <= cnt + 1'b1;
                end
            end else if (flush && (cnt != '0)) begin
                word <= acc;
                vld  <= 1'b1;
                acc  <= '0;
                cnt  <= '0;
            end
        end
    end

    AST_FULL_WORD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (we && cnt == LAST) |=> (vld && cnt == '0)); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (flush && !we && cnt != '0) |=> (vld && cnt == '0)); // R9

    AST_FLUSH_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (flush && !we && cnt == CNTW'(1)) |=> (word[WWL-1:8] == '0)); // R9

endmodule

// File: rtl/bt656_window_capture.sv
module bt656_window_capture
    import bt_cap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    din,
    input  logic          fld_inv,
    input  logic          cap_f1,
    input  logic          cap_f2,
    input  logic [XW-1:0] f1_x_first,
    input  logic [XW-1:0] f1_x_last,
    input  logic [VW-1:0] f1_line_first,
    input  logic [VW-1:0] f1_line_last,
    input  logic [XW-1:0] f2_x_first,
    input  logic [XW-1:0] f2_x_last,
    input  logic [VW-1:0] f2_line_first,
    input  logic [VW-1:0] f2_line_last,
    output logic [WW-1:0] y_word,
    output logic          y_vld,
    output logic [WW-1:0] cb_word,
    output logic          cb_vld,
    output logic [WW-1:0] cr_word,
    output logic          cr_vld,
    output logic          field_done,
    output logic          field_done_id,
    output logic          frame_done,
    output logic          sync_err
);

    logic             code_hit;
    logic             code_ok;
    trs_flags_t       flags;
    logic             trk_active;
    logic [HCW-1:0]   hcount;
    logic [VW-1:0]    vcount;
    logic             field;
    logic             line_end;
    logic [LANES-1:0] lane_we;
    logic [WW-1:0]    lane_word [LANES];
    logic [LANES-1:0] lane_vld;
    win_cfg_t         cfg [2];

    always_comb begin
        cfg[0] = '{en: cap_f1, xs: f1_x_first, xe: f1_x_last, ys: f1_line_first, ye: f1_line_last};
        cfg[1] = '{en: cap_f2, xs: f2_x_first, xe: f2_x_last, ys: f2_line_first, ye: f2_line_last};
    end

    bt_trs_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .code_hit (code_hit),
        .code_ok  (code_ok),
        .flags    (flags),
        .sync_err (sync_err)
    );

    bt_line_tracker u_track (
        .clk           (clk),
        .rst           (rst),
        .din           (din),
        .code_hit      (code_hit),
        .code_ok       (code_ok),
        .flags         (flags),
        .fld_inv       (fld_inv),
        .cap_sel       ({cap_f2, cap_f1}),
        .active        (trk_active),
        .hcount        (hcount),
        .vcount        (vcount),
        .field         (field),
        .line_end      (line_end),
        .field_done    (field_done),
        .field_done_id (field_done_id),
        .frame_done    (frame_done)
    );

    bt_win_gate u_gate (
        .active   (trk_active),
        .line_end (line_end),
        .hcount   (hcount),
        .vcount   (vcount),
        .field    (field),
        .cfg      (cfg),
        .lane_we  (lane_we)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bt_word_pack #(.NB(WBYTES)) u_pack (
            .clk   (clk),
            .rst   (rst),
            .we    (lane_we[g]),
            .flush (line_end),
            .bin   (din),
            .word  (lane_word[g]),
            .vld   (lane_vld[g])
        );
    end

    assign y_word  = lane_word[LANE_Y];
    assign y_vld   = lane_vld[LANE_Y];
    assign cb_word = lane_word[LANE_CB];
    assign cb_vld  = lane_vld[LANE_CB];
    assign cr_word = lane_word[LANE_CR];
    assign cr_vld  = lane_vld[LANE_CR];

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !trk_active |-> (lane_we == '0)); // R3

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_we)); // R4

endmodule

// File: tb/bt656_window_capture_tb_top.sv
`timescale 1ns/1ps
module bt656_window_capture_tb_top;
    import bt_cap_pkg::*;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    din;
    logic          fld_inv, cap_f1, cap_f2;
    logic [XW-1:0] f1_xs, f1_xe, f2_xs, f2_xe;
    logic [VW-1:0] f1_ys, f1_ye, f2_ys, f2_ye;
    logic [WW-1:0] y_word, cb_word, cr_word;
    logic          y_vld, cb_vld, cr_vld;
    logic          field_done, field_done_id, frame_done, sync_err;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] gq_y[$], gq_cb[$], gq_cr[$];
    logic [63:0] eq_y[$], eq_cb[$], eq_cr[$];
    logic [63:0] macc [3];
    int          mcnt [3];

    always #4 clk = ~clk;

    bt656_window_capture dut_i (
        .clk(clk), .rst(rst), .din(din), .fld_inv(fld_inv),
        .cap_f1(cap_f1), .cap_f2(cap_f2),
        .f1_x_first(f1_xs), .f1_x_last(f1_xe), .f1_line_first(f1_ys), .f1_line_last(f1_ye),
        .f2_x_first(f2_xs), .f2_x_last(f2_xe), .f2_line_first(f2_ys), .f2_line_last(f2_ye),
        .y_word(y_word), .y_vld(y_vld), .cb_word(cb_word), .cb_vld(cb_vld),
        .cr_word(cr_word), .cr_vld(cr_vld), .field_done(field_done),
        .field_done_id(field_done_id), .frame_done(frame_done), .sync_err(sync_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (y_vld)  gq_y.push_back(y_word);
            if (cb_vld) gq_cb.push_back(cb_word);
            if (cr_vld) gq_cr.push_back(cr_word);
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        din = b;
    endtask

    function automatic logic [7:0] flag_byte(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic send_code(input logic f, input logic v, input logic h, input logic [7:0] corrupt);
        put(8'hFF); put(8'h00); put(8'h00);
        put(flag_byte(f, v, h) ^ corrupt);
    endtask

    task automatic push_exp(input int lane, input logic [63:0] w);
        case (lane)
            0:       eq_y.push_back(w);
            1:       eq_cb.push_back(w);
            default: eq_cr.push_back(w);
        endcase
    endtask

    task automatic model_byte(input int lane, input logic [7:0] b);
        macc[lane] = macc[lane] | (64'(b) << (8 * mcnt[lane]));
        mcnt[lane]++;
        if (mcnt[lane] == 8) begin
            push_exp(lane, macc[lane]);
            macc[lane] = '0;
            mcnt[lane] = 0;
        end
    endtask

    task automatic model_eol();
        for (int l = 0; l < 3; l++) begin
            if (mcnt[l] > 0) push_exp(l, macc[l]);
            macc[l] = '0;
            mcnt[l] = 0;
        end
    endtask

    // One active line: start code, n samples, end code, blanking (R1 R3 R4 R5 R6 R7)
    task automatic active_line(input logic f, input int vc, input int n, input int seed);
        logic fp;
        logic sel;
        int xs, xe, ys, ye;
        fp  = f ^ fld_inv;
        sel = fp ? cap_f2 : cap_f1;
        xs  = fp ? int'(f2_xs) : int'(f1_xs);
        xe  = fp ? int'(f2_xe) : int'(f1_xe);
        ys  = fp ? int'(f2_ys) : int'(f1_ys);
        ye  = fp ? int'(f2_ye) : int'(f1_ye);
        send_code(f, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'(1 + ((seed * 13 + i * 5) % 250));
            put(b);
            if (sel && vc >= ys && vc <= ye && (i / 2) >= xs && (i / 2) <= xe) begin
                case (i % 4)
                    0:       model_byte(1, b);
                    2:       model_byte(2, b);
                    default: model_byte(0, b);
                endcase
            end
        end
        send_code(f, 1'b0, 1'b1, 8'h00);
        model_eol();
        put(8'h80); put(8'h10);
    endtask

    // Vertical-blanking code with completion checks (R10 R11 R2)
    task automatic blank_code(input logic f, input logic exp_done, input logic exp_id,
                              input logic exp_frame, input string req);
        send_code(f, 1'b1, 1'b1, 8'h00);
        put(8'h80);
        chk(req, "field_done", 64'(field_done), 64'(exp_done));
        if (exp_done) chk(req, "field_done_id", 64'(field_done_id), 64'(exp_id));
        chk(req, "frame_done", 64'(frame_done), 64'(exp_frame));
        chk("R2", "sync_err on accepted code", 64'(sync_err), 64'd0);
        put(8'h10); put(8'h80); put(8'h10);
    endtask

    task automatic compare(input string req);
        chk(req, "Y word count",  64'(gq_y.size()),  64'(eq_y.size()));
        chk(req, "Cb word count", 64'(gq_cb.size()), 64'(eq_cb.size()));
        chk(req, "Cr word count", 64'(gq_cr.size()), 64'(eq_cr.size()));
        for (int k = 0; k < gq_y.size() && k < eq_y.size(); k++)
            chk(req, $sformatf("Y word %0d", k), gq_y[k], eq_y[k]);
        for (int k = 0; k < gq_cb.size() && k < eq_cb.size(); k++)
            chk(req, $sformatf("Cb word %0d", k), gq_cb[k], eq_cb[k]);
        for (int k = 0; k < gq_cr.size() && k < eq_cr.size(); k++)
            chk(req, $sformatf("Cr word %0d", k), gq_cr[k], eq_cr[k]);
        gq_y.delete(); gq_cb.delete(); gq_cr.delete();
        eq_y.delete(); eq_cb.delete(); eq_cr.delete();
    endtask

    task automatic test_reset();
        rst = 1'b1;
        din = 8'h80;
        repeat (3) @(negedge clk);
        chk("R12", "outputs in reset",
            64'({y_vld, cb_vld, cr_vld, field_done, field_done_id, frame_done, sync_err}), 64'd0);
        chk("R12", "y_word in reset",  y_word,  64'd0);
        chk("R12", "cb_word in reset", cb_word, 64'd0);
        chk("R12", "cr_word in reset", cr_word, 64'd0);
        rst = 1'b0;
    endtask

    // Field 0 window, partial flush (R4 R5 R6 R8 R9 R10)
    task automatic test_field1_window();
        fld_inv = 0; cap_f1 = 1; cap_f2 = 0;
        f1_xs = 2; f1_xe = 9; f1_ys = 2; f1_ye = 3;
        f2_xs = 0; f2_xe = 100; f2_ys = 1; f2_ye = 100;
        blank_code(0, 0, 0, 0, "R10");
        active_line(0, 1, 32, 1);
        active_line(0, 2, 32, 2);
        active_line(0, 3, 32, 3);
        blank_code(0, 1, 0, 0, "R10");
        compare("R5_R6_R8_R9");
    endtask

    // Field inversion and selection (R7)
    task automatic test_invert_select();
        fld_inv = 1; cap_f1 = 0; cap_f2 = 1;
        f1_xs = 0; f1_xe = 100; f1_ys = 1; f1_ye = 100;
        f2_xs = 0; f2_xe = 3; f2_ys = 1; f2_ye = 1;
        blank_code(0, 0, 0, 0, "R7");
        active_line(0, 1, 16, 4);
        active_line(0, 2, 16, 5);
        blank_code(1, 1, 1, 0, "R7");
        active_line(1, 1, 16, 6);
        blank_code(1, 0, 0, 0, "R7");
        compare("R7");
    endtask

    // Corrupted codes are flagged and ignored (R2 R3)
    task automatic test_bad_codes();
        fld_inv = 0; cap_f1 = 1; cap_f2 = 0;
        f1_xs = 0; f1_xe = 100; f1_ys = 1; f1_ye = 1;
        blank_code(0, 0, 0, 0, "R2");
        send_code(0, 0, 0, 8'h01);
        put(8'h22);
        chk("R2", "sync_err after bad protection", 64'(sync_err), 64'd1);
        put(8'h33);
        chk("R2", "sync_err single pulse", 64'(sync_err), 64'd0);
        for (int i = 0; i < 12; i++) put(8'(8'h40 + i));
        send_code(0, 0, 0, 8'h80);
        put(8'h55);
        chk("R2", "sync_err after clear MSB", 64'(sync_err), 64'd1);
        for (int i = 0; i < 6; i++) put(8'(8'h60 + i));
        put(8'h80);
        active_line(0, 1, 8, 7);
        blank_code(0, 1, 0, 0, "R2");
        compare("R2_R3");
    endtask

    // Frame capture over both fields, sample 0 at window edge (R1 R6 R11)
    task automatic test_frame();
        fld_inv = 0; cap_f1 = 1; cap_f2 = 1;
        f1_xs = 0; f1_xe = 1; f1_ys = 1; f1_ye = 1;
        f2_xs = 4; f2_xe = 5; f2_ys = 2; f2_ye = 2;
        blank_code(0, 0, 0, 0, "R11");
        active_line(0, 1, 12, 8);
        blank_code(1, 1, 0, 0, "R11");
        active_line(1, 1, 12, 9);
        active_line(1, 2, 12, 10);
        blank_code(0, 1, 1, 1, "R11");
        compare("R1_R6");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=complete");
        finish_run();
    end

    initial begin
        fld_inv = 0; cap_f1 = 0; cap_f2 = 0;
        f1_xs = 0; f1_xe = 0; f1_ys = 0; f1_ye = 0;
        f2_xs = 0; f2_xe = 0; f2_ys = 0; f2_ye = 0;
        for (int l = 0; l < 3; l++) begin
            macc[l] = '0;
            mcnt[l] = 0;
        end
        test_reset();
        repeat (4) put(8'h80);
        test_field1_window();
        test_invert_select();
        test_bad_codes();
        test_frame();
        repeat (8) put(8'h80);
        finish_run();
    end

endmodule